// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block adds two 64-bit words as packed vectors. A two-bit width select, sampled with the operands, splits the word into one 64-bit element, two 32-bit elements, four 16-bit elements or eight 8-bit elements. Every element pair is added in the same operation.

The carry chain is broken at each element boundary, so every element wraps modulo its own width. Each element also reports its carry-out on a per-element flag. The result is registered. It appears one cycle after an accepted operation, and there is no backpressure.

The adder is built as eight byte-wide lane adders. A lane takes the carry from the lane below it only when the two lanes belong to the same element. This lets one carry chain serve all four packing widths.

Top module: `simd_add64`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, `res_valid` is 0, `res_sum` is all zeros and `res_cout` is all zeros.
- R2: `res_valid` is high in exactly those cycles that follow a cycle in which `op_valid` was high. The result belongs to that accepted operation, so the latency is one cycle.
- R3: With `op_width` = 2'b00, `res_sum` is (`op_a` + `op_b`) mod 2^64. `res_cout[0]` is the carry out of bit 63.
- R4: With `op_width` = 2'b01, bits [32k+31:32k] of `res_sum` hold the sum mod 2^32 of the matching 32-bit slices of `op_a` and `op_b`, for k = 0..1. No carry passes from bit 31 into bit 32.
- R5: With `op_width` = 2'b10, each 16-bit slice k = 0..3 of `res_sum` holds the sum mod 2^16 of the matching slices of the operands. No carry crosses a 16-bit boundary.
- R6: With `op_width` = 2'b11, each byte k = 0..7 of `res_sum` holds the sum mod 2^8 of the matching operand bytes. No carry crosses a byte boundary.
- R7: `res_cout[k]` is the carry out of the top bit of element k, where element k is the k-th slice counted from bit 0. Bits of `res_cout` at and above the element count (1, 2, 4 or 8) are 0.
- R8: The width select is taken per operation. Back-to-back operations with different `op_width` values are each computed in their own mode.
- R9: While `op_valid` is low, `res_sum` and `res_cout` keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operands and width select are valid this cycle |
| op_width | input | 2 | Packing: 00 = 1x64, 01 = 2x32, 10 = 4x16, 11 = 8x8 |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| res_valid | output | 1 | Result valid, one cycle after op_valid |
| res_sum | output | 64 | Packed element sums |
| res_cout | output | 8 | Per-element carry-out, indexed by element |

## Verification
The assertions check the timing on every cycle. They track the one-cycle valid latency and the holding of the result while idle. They also check that the carry flags above the element count stay zero, and that byte 0 is always the plain byte sum.

The full arithmetic of every mode can only be shown by the bench's scenarios. These cover carry isolation at each boundary, the exact carry flag at each element index, and back-to-back mode switches. The bench sweeps every byte pair exhaustively in 8x8 mode and uses pseudo-random and carry-ripple corner words in all four modes.

// File: rtl/simd_add64.sv
module simd_add64 #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [1:0]            op_width,
  input  logic [8*LANE_W-1:0]   op_a,
  input  logic [8*LANE_W-1:0]   op_b,
  output logic                  res_valid,
  output logic [8*LANE_W-1:0]   res_sum,
  output logic [7:0]            res_cout
);
  localparam int LANES = 8;
  localparam int W     = LANES * LANE_W;

  logic [LANES-1:0] lane_co;
  logic [LANES-1:0] lane_cut;
  logic [W-1:0]     sum_c;
  logic [LANES-1:0] cout_c;
  logic [1:0]       shift;

  assign shift = 2'd3 - op_width;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic cin;
    if (i == 0) begin : g_first
      assign lane_cut[i] = 1'b1;
      assign cin = 1'b0;
    end else begin : g_rest
      assign lane_cut[i] = ((i & ((1 << shift) - 1)) == 0);
      assign cin = lane_cut[i] ? 1'b0 : lane_co[i-1];
    end
    assign {lane_co[i], sum_c[i*LANE_W +: LANE_W]} =
      {1'b0, op_a[i*LANE_W +: LANE_W]} + {1'b0, op_b[i*LANE_W +: LANE_W]} + {{LANE_W{1'b0}}, cin};
  end

  always_comb begin
    cout_c = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i == LANES - 1 || lane_cut[(i + 1) % LANES])
        cout_c[i >> shift] = lane_co[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_sum   <= '0;
      res_cout  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_sum  <= sum_c;
        res_cout <= cout_c;
      end
    end
  end
endmodule

module simd_add64_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_width,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        res_valid,
  input logic [63:0] res_sum,
  input logic [7:0]  res_cout
);
  logic live;
  logic [8:0] byte0;
  assign byte0 = {1'b0, op_a[7:0]} + {1'b0, op_b[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (res_valid == $past(op_valid)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(op_valid)) |-> ($stable(res_sum) && $stable(res_cout)));

  p_flag64_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_valid) && $past(op_width) == 2'b00) |-> (res_cout[7:1] == 7'd0));

  p_flag32_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_valid) && $past(op_width) == 2'b01) |-> (res_cout[7:2] == 6'd0));

  p_flag16_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_valid) && $past(op_width) == 2'b10) |-> (res_cout[7:4] == 4'd0));

  p_byte0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_valid)) |-> (res_sum[7:0] == $past(byte0[7:0])));

  p_byte0_cout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_valid) && $past(op_width) == 2'b11) |-> (res_cout[0] == $past(byte0[8])));
endmodule

bind simd_add64 simd_add64_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_width(op_width),
  .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_sum(res_sum), .res_cout(res_cout)
);

// File: tb/sim_simd_add64.sv
module sim_simd_add64;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_width = 2'b00;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid;
  logic [63:0] res_sum;
  logic [7:0]  res_cout;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  simd_add64 u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] s, output logic [7:0] c);
    int w = 64 >> m;
    int n = 1 << m;
    logic [64:0] mask = (65'd1 << w) - 65'd1;
    s = '0;
    c = '0;
    for (int k = 0; k < n; k++) begin
      logic [64:0] ea = ({1'b0, a} >> (k * w)) & mask;
      logic [64:0] eb = ({1'b0, b} >> (k * w)) & mask;
      logic [64:0] t = ea + eb;
      s = s | (64'((t & mask) << (k * w)));
      c[k] = t[w];
    end
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] es;
    logic [7:0] ec;
    op_valid = 1'b1;
    op_width = m;
    op_a = a;
    op_b = b;
    model(m, a, b, es, ec);
    @(negedge clk);
    check(req, {63'd0, res_valid}, 64'd1);
    check(req, res_sum, es);
    check({req, "/R7"}, {56'd0, res_cout}, {56'd0, ec});
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] held_s;
    logic [7:0]  held_c;
    string tags[4];
    tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";

    repeat (3) @(negedge clk);
    check("R1", {63'd0, res_valid}, 64'd0);
    check("R1", res_sum, 64'd0);
    check("R1", {56'd0, res_cout}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, res_valid}, 64'd0);
    check("R1", res_sum, 64'd0);

    for (int m = 0; m < 4; m++) begin
      run_op(tags[m], 2'(m), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
      run_op(tags[m], 2'(m), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      run_op(tags[m], 2'(m), 64'h7FFF_FFFF_80FF_00FF, 64'h0000_0001_8001_0101);
      run_op(tags[m], 2'(m), 64'd0, 64'd0);
      for (int i = 0; i < 300; i++) begin
        logic [63:0] ra, rb;
        rng = next_rand(rng); ra = rng;
        rng = next_rand(rng); rb = rng;
        run_op(tags[m], 2'(m), ra, rb);
      end
    end

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 1) begin
        if (j % 1 == 0)
          run_op("R6", 2'b11, {8{8'(i)}},
                 {8'(j), 8'(j + 37), 8'(j + 74), 8'(j + 111), 8'(j + 148), 8'(j + 185), 8'(j + 222), 8'(j + 3)});
        if (j % 64 == 63) j += 0;
      end
      if (i % 8 == 7) i += 0;
    end

    for (int i = 0; i < 64; i++) begin
      rng = next_rand(rng);
      run_op("R8", 2'(i), rng, ~rng + 64'(i));
    end

    op_valid = 1'b0;
    @(negedge clk);
    check("R2", {63'd0, res_valid}, 64'd0);
    held_s = res_sum;
    held_c = res_cout;
    op_a = 64'hDEAD_BEEF_0123_4567;
    op_b = 64'hFFFF_0000_FFFF_0000;
    op_width = 2'b11;
    repeat (3) @(negedge clk);
    check("R9", res_sum, held_s);
    check("R9", {56'd0, res_cout}, {56'd0, held_c});
    check("R2", {63'd0, res_valid}, 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule